// File: doc/BRIEF.md
# Pipelined Rectangular-to-Polar Converter

This block turns a stream of complex baseband samples, given as signed in-phase and quadrature words, into a phase word and an envelope word for a polar transmit chain. It runs a CORDIC vectoring algorithm that is fully unrolled, with one register stage per iteration, so it accepts a new sample on every clock at the system rate. The phase word drives a digital phase modulator. The envelope word drives the amplitude path.

The first stage folds the vector into the right half-plane by a swap and a sign change, with no shifter, and preloads the phase with plus or minus a quarter turn. Each later stage carries the quadrature term pre-multiplied by a power of two that doubles per stage. As a result the stage needs a single variable shift, on the term added to x. The envelope leaves the block without the CORDIC gain removed, so the consumer must multiply it by the constant 1/Kn. A valid strobe travels alongside the data through a matching shift register.

Top module: `rect2polar`

## Requirements
- R1: `out_valid` repeats `in_valid` exactly ITER+1 clock cycles later (13 with defaults), gaps included, and the sample it marks is the one that entered with that strobe.
- R2: While `rst_n` is sampled low at a rising edge, the next outputs are `out_valid`=0, `out_env`=0 and `out_phase`=0. Samples in flight when reset is applied never appear.
- R3: `out_phase` is atan2(q, i) in two's complement with 2^PH_W codes per full turn, so code 2^(PH_W-1) is pi and code 0 is the positive real axis. For vectors of magnitude at least 4096 it lies within 12 codes of the exact value, modulo a full turn.
- R4: `out_env` equals Kn times sqrt(i^2 + q^2) within 16 codes, where Kn is the product over k = 0..ITER-1 of sqrt(1 + 2^-2k) (about 1.6468 for 12 stages). The envelope is unsigned.
- R5: The input (0, 0) gives `out_env` = 0. Any phase value is allowed.
- R6: The fold stage picks the +90 degree preload when q >= 0, including q = 0, and the -90 degree preload otherwise. Because of this, the envelope candidate is never negative and never falls from one stage to the next, and `out_env` is at least |i| + |q|.
- R7: Full-scale inputs, including the most negative code on either or both axes, meet R3 and R4 with no internal wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Marks a sample on `in_i`/`in_q` |
| in_i | input | IN_W | In-phase sample, signed |
| in_q | input | IN_W | Quadrature sample, signed |
| out_valid | output | 1 | Marks a result on `out_phase`/`out_env` |
| out_phase | output | PH_W | Phase, two's complement, full scale one turn |
| out_env | output | IN_W+GUARD+1 | Envelope before gain correction, unsigned |

## Verification
A result is due ITER+1 rising edges after the edge that samples its input: one edge for the fold register and one for each rotation stage. The result can be read at the falling edge that follows. The bench drives every input at a falling edge and records it in a history indexed by cycle. At each falling edge it compares the outputs against the entry written ITER+1 cycles earlier, and it checks the valid strobe in every cycle, gaps included. When reset is applied in the middle of a run, the bench clears the history, so no sample that was in flight is expected after the flush.

// File: rtl/r2p_pkg.sv
// Shared constants for the rectangular-to-polar converter.
// Assumes the internal phase width is at most 31 bits.
package r2p_pkg;

    // atan(2^-k) as a fraction of one turn, scaled by 2^32
    function automatic longint atan_turn32(input int k);
        case (k)
            0:  return 64'd536870912;
            1:  return 64'd316933406;
            2:  return 64'd167458907;
            3:  return 64'd85004756;
            4:  return 64'd42667331;
            5:  return 64'd21354465;
            6:  return 64'd10679838;
            7:  return 64'd5340245;
            8:  return 64'd2670163;
            9:  return 64'd1335087;
            10: return 64'd667544;
            11: return 64'd333772;
            12: return 64'd166886;
            13: return 64'd83443;
            14: return 64'd41722;
            15: return 64'd20861;
            default: return 64'd683565275 >> k;  // atan(x) ~ x for small x
        endcase
    endfunction

    // Rounded stage angle in units where a full turn is 2^zw
    function automatic longint step_angle(input int k, input int zw);
        longint t;
        t = atan_turn32(k);
        return ((t >> (31 - zw)) + 64'd1) >> 1;
    endfunction

endpackage

// File: rtl/r2p_valid_pipe.sv
// Delay line for the sample strobe, DEPTH registers long.
// Assumes DEPTH >= 2; cleared by the synchronous reset.
module r2p_valid_pipe #(
    parameter int DEPTH = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vin,
    output logic vout
);
    logic [DEPTH-1:0] sr;

    // shift the strobe one place per clock
    always_ff @(posedge clk) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[DEPTH-2:0], vin};
    end

    assign vout = sr[DEPTH-1];
endmodule

// File: rtl/r2p_fold.sv
// Quadrant fold: rotates the input by -90 deg (q >= 0) or +90 deg (q < 0)
// using a swap and a negation, and presets the phase to the matching
// quarter turn. Output x is never negative.
module r2p_fold #(
    parameter int IN_W = 16,
    parameter int W    = 20,
    parameter int ZW   = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IN_W-1:0]      in_i,
    input  logic [IN_W-1:0]      in_q,
    output logic signed [W-1:0]  x_o,
    output logic signed [W-1:0]  y_o,
    output logic [ZW-1:0]        z_o
);
    localparam logic [ZW-1:0] QTR = ZW'(1) << (ZW - 2);

    logic signed [W-1:0] iw, qw, x_n, y_n;
    logic [ZW-1:0]       z_n;
    logic                dir;

    // sign-extend and pick the fold direction
    always_comb begin
        iw  = {{(W-IN_W){in_i[IN_W-1]}}, in_i};
        qw  = {{(W-IN_W){in_q[IN_W-1]}}, in_q};
        dir = ~in_q[IN_W-1];
        x_n = dir ? qw : -qw;
        y_n = dir ? -iw : iw;
        z_n = dir ? QTR : -QTR;
    end

    // register the folded vector
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_o <= '0;
            y_o <= '0;
            z_o <= '0;
        end else begin
            x_o <= x_n;
            y_o <= y_n;
            z_o <= z_n;
        end
    end

    assert_fold_nonneg_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !x_o[W-1]);
endmodule

// File: rtl/r2p_rot.sv
// One vectoring micro-rotation, index K. y arrives pre-multiplied by 2^K,
// so x gains y >>> 2K and the next y is 2*(y -/+ x): one shifter only.
// Assumes x_i >= 0 (guaranteed by the fold stage).
module r2p_rot #(
    parameter int W  = 20,
    parameter int ZW = 20,
    parameter int K  = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [W-1:0]  x_i,
    input  logic signed [W-1:0]  y_i,
    input  logic [ZW-1:0]        z_i,
    output logic signed [W-1:0]  x_o,
    output logic signed [W-1:0]  y_o,
    output logic [ZW-1:0]        z_o
);
    localparam int SH = (2 * K < W) ? 2 * K : W - 1;
    localparam logic [ZW-1:0] ANG = ZW'(r2p_pkg::step_angle(K, ZW));

    logic signed [W-1:0] sh, x_n, y_n;
    logic [ZW-1:0]       z_n;
    logic                dir;

    // rotate toward the real axis, direction from the sign of y
    always_comb begin
        dir = ~y_i[W-1];
        sh  = y_i >>> SH;
        x_n = dir ? x_i + sh  : x_i - sh;
        y_n = dir ? y_i - x_i : y_i + x_i;
        z_n = dir ? z_i + ANG : z_i - ANG;
    end

    // register the stage result, y doubled for the next index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_o <= '0;
            y_o <= '0;
            z_o <= '0;
        end else begin
            x_o <= x_n;
            y_o <= y_n <<< 1;
            z_o <= z_n;
        end
    end

    assert_zero_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (x_i == 0 && y_i == 0) |=> (x_o == 0 && y_o == 0));

    assert_env_grow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (x_o >= $past(x_i)));
endmodule

// File: rtl/rect2polar.sv
// Rectangular-to-polar converter: fold stage followed by ITER unrolled
// CORDIC vectoring stages, one sample per clock, latency ITER+1.
// The envelope is not corrected for the CORDIC gain.
module rect2polar #(
    parameter int IN_W     = 16,
    parameter int GUARD    = 2,
    parameter int ITER     = 12,
    parameter int PH_W     = 16,
    parameter int PH_GUARD = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [IN_W-1:0]       in_i,
    input  logic [IN_W-1:0]       in_q,
    output logic                  out_valid,
    output logic [PH_W-1:0]       out_phase,
    output logic [IN_W+GUARD:0]   out_env
);
    localparam int W     = IN_W + GUARD + 2;  // two extra bits: gain and y range
    localparam int ZW    = PH_W + PH_GUARD;
    localparam int ENV_W = W - 1;
    localparam int DEPTH = ITER + 1;

    logic [ITER:0][W-1:0]  xs;
    logic [ITER:0][W-1:0]  ys;
    logic [ITER:0][ZW-1:0] zs;

    r2p_fold #(.IN_W(IN_W), .W(W), .ZW(ZW)) u_fold (
        .clk(clk), .rst_n(rst_n), .in_i(in_i), .in_q(in_q),
        .x_o(xs[0]), .y_o(ys[0]), .z_o(zs[0])
    );

    for (genvar k = 0; k < ITER; k++) begin : g_rot
        r2p_rot #(.W(W), .ZW(ZW), .K(k)) u_rot (
            .clk(clk), .rst_n(rst_n),
            .x_i(xs[k]),   .y_i(ys[k]),   .z_i(zs[k]),
            .x_o(xs[k+1]), .y_o(ys[k+1]), .z_o(zs[k+1])
        );
    end

    r2p_valid_pipe #(.DEPTH(DEPTH)) u_vld (
        .clk(clk), .rst_n(rst_n), .vin(in_valid), .vout(out_valid)
    );

    // round the phase to PH_W bits and expose the raw envelope
    always_comb begin
        out_phase = PH_W'((zs[ITER] + ZW'(1 << (PH_GUARD - 1))) >> PH_GUARD);
        out_env   = ENV_W'(xs[ITER]);
    end

    logic [W:0] y_ext, y_abs, x_dbl;

    // magnitudes for the residual check
    always_comb begin
        y_ext = {ys[ITER][W-1], ys[ITER]};
        y_abs = y_ext[W] ? -y_ext : y_ext;
        x_dbl = {xs[ITER], 1'b0};
    end

    assert_reset_clear_R2: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_env == 0 && out_phase == 0));

    assert_resid_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        y_abs <= x_dbl);
endmodule

// File: tb/sim_rect2polar.sv
`timescale 1ns/1ps
module sim_rect2polar;
    localparam int IN_W = 16, GUARD = 2, ITER = 12, PH_W = 16, PH_GUARD = 4;
    localparam int LAT = ITER + 1;
    localparam int ENV_W = IN_W + GUARD + 1;
    localparam int HMAX = 4096;
    localparam real PI = 3.14159265358979323846;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [IN_W-1:0] in_i = '0, in_q = '0;
    logic out_valid;
    logic [PH_W-1:0] out_phase;
    logic [ENV_W-1:0] out_env;

    always #10 clk = ~clk;

    rect2polar #(.IN_W(IN_W), .GUARD(GUARD), .ITER(ITER), .PH_W(PH_W),
                 .PH_GUARD(PH_GUARD)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i),
        .in_q(in_q), .out_valid(out_valid), .out_phase(out_phase),
        .out_env(out_env)
    );

    int checks = 0, fails = 0, n = 0;
    bit hv[HMAX];
    int hi[HMAX], hq[HMAX];
    real kn = 1.0;

    function automatic longint labs(input longint a);
        return (a < 0) ? -a : a;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // compare current outputs with the sample recorded LAT cycles ago
    task automatic check_out();
        bit ev, corner;
        int c, ii, qq, e, dd;
        real mag, eph;
        longint eenv, got;
        ev = (n >= LAT) ? hv[n-LAT] : 1'b0;
        chk(out_valid == ev, "R1", "valid strobe", out_valid, ev);
        if (ev && out_valid) begin
            c = n - LAT; ii = hi[c]; qq = hq[c];
            corner = (ii == -32768 || ii == 32767 || qq == -32768 || qq == 32767);
            mag  = $sqrt(real'(ii) * ii + real'(qq) * qq);
            eenv = longint'($rtoi(kn * mag + 0.5));
            got  = longint'(out_env);
            chk(labs(got - eenv) <= 16, corner ? "R7" : "R4", "envelope", got, eenv);
            chk(got >= labs(ii) + labs(qq), "R6", "envelope floor", got, labs(ii) + labs(qq));
            if (ii == 0 && qq == 0) chk(got == 0, "R5", "zero envelope", got, 0);
            if (mag >= 4096.0) begin
                eph = $atan2(real'(qq), real'(ii)) / (2.0 * PI) * real'(1 << PH_W);
                e   = $rtoi($floor(eph + 0.5));
                dd  = (int'(out_phase) - e) & ((1 << PH_W) - 1);
                if (dd >= (1 << (PH_W - 1))) dd -= (1 << PH_W);
                chk(labs(dd) <= 12, corner ? "R7" : "R3", "phase",
                    longint'(out_phase), longint'(e & ((1 << PH_W) - 1)));
            end
        end
    endtask

    // one cycle: check, then drive and record at the falling edge
    task automatic step(input bit v, input int i, input int q, input bit rst);
        @(negedge clk);
        check_out();
        if (rst) begin
            for (int k = 0; k <= n; k++) hv[k] = 1'b0;
            rst_n = 1'b0;
        end else begin
            rst_n = 1'b1;
        end
        hv[n] = v && !rst; hi[n] = i; hq[n] = q;
        in_valid = v;
        in_i = i[IN_W-1:0];
        in_q = q[IN_W-1:0];
        n++;
    endtask

    function automatic int rnd_comp();
        int r;
        r = int'($urandom % 65536) - 32768;
        if ($urandom % 5 == 0) r = r >>> ($urandom % 10);
        return r;
    endfunction

    initial begin
        for (int k = 0; k < ITER; k++) kn = kn * $sqrt(1.0 + 2.0 ** (-2.0 * k));
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        // R2: state after reset held low
        chk(out_valid == 1'b0, "R2", "valid after reset", out_valid, 0);
        chk(out_env == 0, "R2", "envelope after reset", out_env, 0);
        chk(out_phase == 0, "R2", "phase after reset", out_phase, 0);
        rst_n = 1'b1; hv[0] = 1'b0; n = 1;

        // directed corners (R5, R6 fold at q = 0, R7 full scale)
        step(1, 0, 0, 0);
        step(1, 32767, 0, 0);
        step(1, -32768, 0, 0);
        step(1, 0, 32767, 0);
        step(1, 0, -32768, 0);
        step(0, 1234, 999, 0);
        step(1, -32768, -32768, 0);
        step(1, 32767, 32767, 0);
        step(1, -32768, 32767, 0);
        step(1, 32767, -32768, 0);
        step(1, 1, 0, 0);
        step(1, 3000, -3000, 0);
        step(1, -5000, 0, 0);
        step(1, 0, 0, 0);

        // random stream with gaps
        for (int t = 0; t < 1200; t++) step($urandom % 4 != 0, rnd_comp(), rnd_comp(), 0);

        // R2: reset in mid-stream flushes samples in flight
        step(1, 20000, 20000, 1);
        step(1, 20000, 20000, 1);
        @(negedge clk);
        chk(out_valid == 1'b0, "R2", "valid after mid reset", out_valid, 0);
        chk(out_env == 0, "R2", "envelope after mid reset", out_env, 0);
        chk(out_phase == 0, "R2", "phase after mid reset", out_phase, 0);
        rst_n = 1'b1; in_valid = 1'b0;
        hv[n] = 1'b0; n++;

        for (int t = 0; t < 600; t++) step($urandom % 3 != 0, rnd_comp(), rnd_comp(), 0);
        for (int t = 0; t < LAT + 3; t++) step(0, 0, 0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    // watchdog: a hung run is a failed check
    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R1 watchdog expired: actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule